// File: doc/BRIEF.md
# PCM Time-Slot Sequencer

This block sequences four PCM channels that share a single serial transmit line and a single serial receive line. It runs from the master bit clock, at 2.048 MHz for 32 slots per frame or 4.096 MHz for 64 slots, and takes an 8 kHz frame separation pulse that marks the start of slot 0. Channel slots are not programmed. Each channel has its own frame sync input, and the block works out the slot number from where that sync lands relative to the separation pulse. It then shifts the channel's parallel byte out on the shared transmit line, sign bit first, during that slot.

The width of the separation pulse sets how far the receive sampling point trails the transmit bit. The block produces a per-channel receive strobe that lags each transmit bit by that many clock periods. It assembles the received byte and flags it with a one-cycle valid pulse. A sync that lands off a slot boundary, lands outside the frame, arrives before any separation pulse, or lands in or next to a slot already claimed by another channel is refused and reported. The last good slot assignment of that channel is kept.

All logic works on rising edges of `clk`. A cycle in which a receive strobe is high stands for the falling edge inside that cycle. The received line is captured at the rising edge that closes the cycle.

Top module: `pcm_slot_seq`

## Requirements
- R1: While reset is low and right after it is released, `tx_oe_o`, `tx_o`, `rx_stb_o`, `rx_vld_o`, `slot_ok_o`, `sync_err_o` and `rx_delay_o` are all zero.
- R2: A frame sync rising edge sampled 8·k clock edges after the edge that samples `sep_i` rising (k ≥ 0, same edge allowed) is accepted as slot k. From the next cycle, `slot_o[c*6 +: 6]` reads k and `slot_ok_o[c]` is 1.
- R3: When channel c's sync is accepted at edge E, `tx_byte_i[c*8 +: 8]` is taken at E. `tx_oe_o` is 1 for the 8 cycles after E, and `tx_o` carries bits 7 down to 0, one per cycle.
- R4: Outside an accepted channel's 8-cycle window, `tx_oe_o` and `tx_o` are 0.
- R5: If `sep_i` is sampled high on W consecutive edges, then at the edge that samples it low `rx_delay_o` becomes W−1, saturating at 63.
- R6: For a sync accepted at edge E, `rx_stb_o[c]` is 1 for the 8 cycles after edge E+D, where D is the `rx_delay_o` value before E. With D = 0 the strobe coincides with the transmit bit, which is the half-period case.
- R7: `rx_i` is captured at each edge that ends a strobe cycle, MSB first. One cycle after the eighth capture, `rx_vld_o[c]` pulses for one cycle and `rx_byte_o[c*8 +: 8]` holds the byte.
- R8: A sync whose offset from the separation edge is not a multiple of 8 is refused. `sync_err_o[c]` is 1 for the next cycle, nothing is transmitted, and `slot_o`/`slot_ok_o` keep their previous values.
- R9: A sync is refused (as in R8) if another channel's sync rises on the same edge, or if another channel already took the same or an adjacent slot in this frame.
- R10: With `wide_i` = 0, slots 32 and above are refused. With `wide_i` = 1, slots up to 63 are accepted.
- R11: A sync that arrives before any separation pulse has been seen since reset is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_i | input | 1 | 1 = 64-slot frame, 0 = 32-slot frame |
| sep_i | input | 1 | Frame separation pulse, marks slot 0 and sets the receive lag |
| fsx_i | input | 4 | Per-channel transmit frame sync |
| tx_byte_i | input | 32 | Per-channel transmit byte, channel c at bits c*8 +: 8 |
| tx_o | output | 1 | Shared serial transmit data |
| tx_oe_o | output | 1 | Transmit drive enable, low means high impedance |
| rx_i | input | 1 | Shared serial receive data |
| rx_stb_o | output | 4 | Per-channel receive sample strobe |
| rx_byte_o | output | 32 | Per-channel received byte |
| rx_vld_o | output | 4 | Per-channel one-cycle byte-valid pulse |
| slot_o | output | 24 | Per-channel last accepted slot, 6 bits each |
| slot_ok_o | output | 4 | Per-channel slot-assigned flag |
| sync_err_o | output | 4 | Per-channel one-cycle sync refusal pulse |
| rx_delay_o | output | 6 | Current transmit-to-receive lag in clock periods |

## Verification
The bench places syncs at slot 0 on the same edge as the separation pulse, at the last slot of each frame size, one slot apart, on the same edge as each other, and off the 8-period boundary. A design that measured offsets from the wrong edge would report slots off by one. A design that let clashes through would drive two bytes on top of each other on the shared line, and a design that dropped the held assignment would lose the slot on a refusal. Separation widths of 1, 2, 4, 9 and 70 periods check the minus-one rule, the zero-lag case and saturation. Strobes placed one cycle early or late, or a byte assembled in the wrong bit order, show up as mismatches on `rx_byte_o`. A slot-0 sync whose separation pulse is still high must use the previous frame's lag. That catches a design that applies a new lag too soon.

// File: rtl/pcm_slot_seq_pkg.sv
package pcm_slot_seq_pkg;

  // slot index of an edge count measured from the separation edge
  function automatic int unsigned slot_of(input int unsigned elapsed, input int unsigned bits);
    return elapsed / bits;
  endfunction

  // true when the edge count sits on a slot boundary
  function automatic bit on_boundary(input int unsigned elapsed, input int unsigned bits);
    return (elapsed % bits) == 0;
  endfunction

  // true when two slots are equal or neighbours
  function automatic bit too_close(input int unsigned a, input int unsigned b);
    return (a == b) || (a == b + 1) || (b == a + 1);
  endfunction

  // receive lag from a high-width count: width minus one, width capped
  function automatic int unsigned lag_of(input int unsigned width, input int unsigned cap);
    int unsigned w;
    w = (width > cap) ? cap : width;
    return (w == 0) ? 0 : w - 1;
  endfunction

endpackage

// File: rtl/pcm_slot_seq_frame.sv
module pcm_slot_seq_frame
  import pcm_slot_seq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sep_i,
  output logic             frame_start,
  output logic [CNT_W-1:0] elapsed,
  output logic             framed,
  output logic [DLY_W-1:0] rx_dly
);
  localparam int WC_W = DLY_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [WC_W-1:0]  WC_CAP  = WC_W'(1 << DLY_W);

  logic             sep_q, framed_q, sep_fall;
  logic [CNT_W-1:0] cnt_q;
  logic [WC_W-1:0]  wc_q;

  assign frame_start = sep_i & ~sep_q;
  assign sep_fall    = sep_q & ~sep_i;
  assign framed      = framed_q | frame_start;

  always_comb begin
    if (frame_start)         elapsed = '0;
    else if (cnt_q == CNT_MAX) elapsed = cnt_q;
    else                     elapsed = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sep_q    <= 1'b0;
      framed_q <= 1'b0;
      cnt_q    <= '0;
      wc_q     <= '0;
      rx_dly   <= '0;
    end else begin
      sep_q    <= sep_i;
      framed_q <= framed;
      cnt_q    <= elapsed;
      if (frame_start)
        wc_q <= WC_W'(1);
      else if (sep_i && sep_q && wc_q != WC_CAP)
        wc_q <= wc_q + 1'b1;
      if (sep_fall)
        rx_dly <= DLY_W'(lag_of(32'(wc_q), 32'(1 << DLY_W)));
    end
  end
endmodule

// File: rtl/pcm_slot_seq_sync.sv
module pcm_slot_seq_sync
  import pcm_slot_seq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int MAX_SLOTS = 64,
  parameter int SLOT_BITS = 8,
  parameter int SLOT_W    = 6,
  parameter int CNT_W     = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wide_i,
  input  logic [NCH-1:0]        fsx_i,
  input  logic                  frame_start,
  input  logic                  framed,
  input  logic [CNT_W-1:0]      elapsed,
  output logic [NCH-1:0]        acc,
  output logic [NCH-1:0]        rej,
  output logic [NCH*SLOT_W-1:0] slot_o,
  output logic [NCH-1:0]        slot_ok_o,
  output logic [NCH-1:0]        err_o
);
  logic [NCH-1:0]    fsx_q, hit, taken_q, taken_eff, clash;
  logic [SLOT_W-1:0] slot_q [NCH];
  int unsigned       e_slot;
  logic              e_edge, e_fits;

  assign hit       = fsx_i & ~fsx_q;
  assign taken_eff = frame_start ? '0 : taken_q;

  always_comb begin
    e_slot = slot_of(32'(elapsed), 32'(SLOT_BITS));
    e_edge = on_boundary(32'(elapsed), 32'(SLOT_BITS));
    e_fits = e_slot < (wide_i ? 32'(MAX_SLOTS) : 32'(MAX_SLOTS / 2));
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      clash[c] = 1'b0;
      for (int d = 0; d < NCH; d++)
        if (d != c && (hit[d] || (taken_eff[d] && too_close(32'(slot_q[d]), e_slot))))
          clash[c] = 1'b1;
    end
  end

  assign acc = hit & {NCH{framed & e_edge & e_fits}} & ~clash;
  assign rej = hit & ~acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsx_q     <= '0;
      taken_q   <= '0;
      err_o     <= '0;
      slot_ok_o <= '0;
      for (int c = 0; c < NCH; c++) slot_q[c] <= '0;
    end else begin
      fsx_q     <= fsx_i;
      taken_q   <= taken_eff | acc;
      err_o     <= rej;
      slot_ok_o <= slot_ok_o | acc;
      for (int c = 0; c < NCH; c++)
        if (acc[c]) slot_q[c] <= SLOT_W'(e_slot);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    assign slot_o[c*SLOT_W +: SLOT_W] = slot_q[c];
  end
endmodule

// File: rtl/pcm_slot_seq_tx.sv
module pcm_slot_seq_tx #(
  parameter int SLOT_BITS = 8,
  parameter int BIT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SLOT_BITS-1:0] byte_i,
  output logic                 bit_o,
  output logic                 act_o
);
  logic [SLOT_BITS-1:0] sh_q;
  logic [BIT_W-1:0]     cnt_q;

  assign bit_o = sh_q[SLOT_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_o <= 1'b0;
    end else if (start) begin
      sh_q  <= byte_i;
      cnt_q <= '0;
      act_o <= 1'b1;
    end else if (act_o) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == BIT_W'(SLOT_BITS - 1)) act_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_slot_seq_rx.sv
module pcm_slot_seq_rx #(
  parameter int SLOT_BITS = 8,
  parameter int BIT_W     = 3,
  parameter int DLY_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DLY_W-1:0]     dly,
  input  logic                 rx_i,
  output logic                 stb_o,
  output logic                 vld_o,
  output logic [SLOT_BITS-1:0] byte_o
);
  logic                 pend_q;
  logic [DLY_W-1:0]     lag_q;
  logic [BIT_W-1:0]     cnt_q;
  logic [SLOT_BITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lag_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      stb_o  <= 1'b0;
      vld_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (start) begin
        cnt_q  <= '0;
        lag_q  <= dly;
        pend_q <= (dly != '0);
        stb_o  <= (dly == '0);
      end else begin
        if (pend_q) begin
          if (lag_q == DLY_W'(1)) begin
            pend_q <= 1'b0;
            stb_o  <= 1'b1;
            cnt_q  <= '0;
          end else begin
            lag_q <= lag_q - 1'b1;
          end
        end
        if (stb_o) begin
          sh_q  <= {sh_q[SLOT_BITS-2:0], rx_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == BIT_W'(SLOT_BITS - 1)) begin
            stb_o  <= 1'b0;
            vld_o  <= 1'b1;
            byte_o <= {sh_q[SLOT_BITS-2:0], rx_i};
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq #(
  parameter int NCH       = 4,
  parameter int MAX_SLOTS = 64,
  parameter int SLOT_BITS = 8,
  parameter int DLY_W     = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wide_i,
  input  logic                          sep_i,
  input  logic [NCH-1:0]                fsx_i,
  input  logic [NCH*SLOT_BITS-1:0]      tx_byte_i,
  output logic                          tx_o,
  output logic                          tx_oe_o,
  input  logic                          rx_i,
  output logic [NCH-1:0]                rx_stb_o,
  output logic [NCH*SLOT_BITS-1:0]      rx_byte_o,
  output logic [NCH-1:0]                rx_vld_o,
  output logic [NCH*$clog2(MAX_SLOTS)-1:0] slot_o,
  output logic [NCH-1:0]                slot_ok_o,
  output logic [NCH-1:0]                sync_err_o,
  output logic [DLY_W-1:0]              rx_delay_o
);
  localparam int SLOT_W = $clog2(MAX_SLOTS);
  localparam int CNT_W  = $clog2(MAX_SLOTS * SLOT_BITS) + 1;
  localparam int BIT_W  = $clog2(SLOT_BITS);

  logic             frame_start, framed;
  logic [CNT_W-1:0] elapsed;
  logic [NCH-1:0]   acc, rej, tx_act, tx_bit;

  pcm_slot_seq_frame #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sep_i(sep_i),
    .frame_start(frame_start), .elapsed(elapsed),
    .framed(framed), .rx_dly(rx_delay_o)
  );

  pcm_slot_seq_sync #(
    .NCH(NCH), .MAX_SLOTS(MAX_SLOTS), .SLOT_BITS(SLOT_BITS),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .fsx_i(fsx_i),
    .frame_start(frame_start), .framed(framed), .elapsed(elapsed),
    .acc(acc), .rej(rej), .slot_o(slot_o),
    .slot_ok_o(slot_ok_o), .err_o(sync_err_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pcm_slot_seq_tx #(.SLOT_BITS(SLOT_BITS), .BIT_W(BIT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(acc[c]),
      .byte_i(tx_byte_i[c*SLOT_BITS +: SLOT_BITS]),
      .bit_o(tx_bit[c]), .act_o(tx_act[c])
    );
    pcm_slot_seq_rx #(.SLOT_BITS(SLOT_BITS), .BIT_W(BIT_W), .DLY_W(DLY_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .start(acc[c]), .dly(rx_delay_o),
      .rx_i(rx_i), .stb_o(rx_stb_o[c]), .vld_o(rx_vld_o[c]),
      .byte_o(rx_byte_o[c*SLOT_BITS +: SLOT_BITS])
    );
  end

  assign tx_oe_o = |tx_act;
  assign tx_o    = |(tx_bit & tx_act);
endmodule

// File: rtl/pcm_slot_seq_chk.sv
module pcm_slot_seq_chk #(
  parameter int NCH    = 4,
  parameter int SLOT_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tx_oe_o,
  input logic [NCH-1:0]        tx_act,
  input logic [NCH-1:0]        acc,
  input logic [NCH-1:0]        rej,
  input logic [NCH-1:0]        sync_err_o,
  input logic [NCH*SLOT_W-1:0] slot_o,
  input logic [NCH-1:0]        slot_ok_o,
  input logic [NCH-1:0]        rx_stb_o,
  input logic [NCH-1:0]        rx_vld_o
);
  assert_one_talker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_act));

  assert_oe_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe_o) |=> tx_oe_o);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_accept_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc[c] |=> slot_ok_o[c] && !sync_err_o[c]);

    assert_refuse_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rej[c] |=> sync_err_o[c] && $stable(slot_o[c*SLOT_W +: SLOT_W]));

    assert_strobe_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_stb_o[c]) |=> rx_stb_o[c]);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld_o[c] |=> !rx_vld_o[c]);
  end
endmodule

bind pcm_slot_seq pcm_slot_seq_chk #(.NCH(NCH), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_oe_o(tx_oe_o), .tx_act(tx_act),
  .acc(acc), .rej(rej), .sync_err_o(sync_err_o), .slot_o(slot_o),
  .slot_ok_o(slot_ok_o), .rx_stb_o(rx_stb_o), .rx_vld_o(rx_vld_o)
);

// File: tb/pcm_slot_seq_bench.sv
`timescale 1ns/1ps
module pcm_slot_seq_bench;
  localparam int NONE = 12'hFFF;
  // {wide, sep width, pos ch0, pos ch1, pos ch2, pos ch3, expected refusal mask ch3..ch0}
  localparam logic [60:0] TBL [7] = '{
    {1'b0, 8'd1,  12'd8,   12'd24,  12'd40,  12'd56,  4'b0000},
    {1'b0, 8'd4,  12'd0,   12'd16,  12'd32,  12'd64,  4'b0000},
    {1'b1, 8'd9,  12'd320, 12'd80,  12'd504, 12'd160, 4'b0000},
    {1'b0, 8'd2,  12'd264, 12'd40,  12'd48,  12'd43,  4'b1101},
    {1'b0, 8'd3,  12'd16,  12'd16,  12'hFFF, 12'd72,  4'b0011},
    {1'b1, 8'd70, 12'd160, 12'hFFF, 12'hFFF, 12'hFFF, 4'b0000},
    {1'b0, 8'd1,  12'd16,  12'd24,  12'd248, 12'hFFF, 4'b0010}
  };

  logic clk = 1'b0, rst_n = 1'b0, wide_i = 1'b0, sep_i = 1'b0, rx_i = 1'b0;
  logic [3:0]  fsx_i = '0;
  logic [31:0] tx_byte_i = '0;
  logic        tx_o, tx_oe_o;
  logic [3:0]  rx_stb_o, rx_vld_o, slot_ok_o, sync_err_o;
  logic [31:0] rx_byte_o;
  logic [23:0] slot_o;
  logic [5:0]  rx_delay_o;

  int checks = 0, failures = 0, dprev = 0;
  int exp_slot [4];
  bit exp_ok [4];

  always #4 clk = ~clk;

  pcm_slot_seq u_pcm_slot_seq (
    .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .sep_i(sep_i), .fsx_i(fsx_i),
    .tx_byte_i(tx_byte_i), .tx_o(tx_o), .tx_oe_o(tx_oe_o), .rx_i(rx_i),
    .rx_stb_o(rx_stb_o), .rx_byte_o(rx_byte_o), .rx_vld_o(rx_vld_o),
    .slot_o(slot_o), .slot_ok_o(slot_ok_o), .sync_err_o(sync_err_o),
    .rx_delay_o(rx_delay_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(tx_oe_o == 0 && tx_o == 0, {req, " tx idle"}, {tx_oe_o, tx_o}, 0);
    chk(rx_stb_o == 0 && rx_vld_o == 0, {req, " rx idle"}, {rx_stb_o, rx_vld_o}, 0);
    chk(slot_ok_o == 0 && sync_err_o == 0, {req, " slot flags"}, {slot_ok_o, sync_err_o}, 0);
    chk(rx_delay_o == 0, {req, " rx_delay"}, rx_delay_o, 0);
  endtask

  task automatic run_frame(input int f);
    logic [60:0] v;
    int pos [4], deff [4], w, dnew, len;
    bit wide, acc [4], refuse [4];
    logic [7:0] txb [4], rxb [4];
    v = TBL[f];
    wide = v[60]; w = int'(v[59:52]);
    pos[0] = int'(v[51:40]); pos[1] = int'(v[39:28]);
    pos[2] = int'(v[27:16]); pos[3] = int'(v[15:4]);
    dnew = ((w > 64) ? 64 : w) - 1;
    len = w + 2;
    for (int c = 0; c < 4; c++) begin
      refuse[c] = v[c];
      acc[c]    = (pos[c] != NONE) && !v[c];
      deff[c]   = (pos[c] > w) ? dnew : dprev;
      txb[c]    = 8'hA5 ^ 8'(c * 37 + f * 11);
      rxb[c]    = 8'h3C ^ 8'(c * 53 + f * 7);
      tx_byte_i[c*8 +: 8] = txb[c];
      if (pos[c] != NONE && pos[c] + deff[c] + 12 > len) len = pos[c] + deff[c] + 12;
    end
    wide_i = wide;
    for (int j = 0; j <= len; j++) begin
      @(negedge clk);
      if (j > 0) begin
        int e;
        bit eo, et;
        e = j - 1; eo = 0; et = 0;
        for (int c = 0; c < 4; c++)
          if (acc[c] && e >= pos[c] && e <= pos[c] + 7) begin
            eo = 1; et = txb[c][7 - (e - pos[c])];
          end
        chk(tx_oe_o == eo, eo ? "R3 tx_oe window" : "R4 tx_oe idle", tx_oe_o, eo);
        chk(tx_o == et, eo ? "R3 tx_o bit" : "R4 tx_o idle", tx_o, et);
        for (int c = 0; c < 4; c++) begin
          bit es, ev, ee;
          es = acc[c] && e >= pos[c] + deff[c] && e <= pos[c] + deff[c] + 7;
          ev = acc[c] && e == pos[c] + deff[c] + 8;
          ee = refuse[c] && e == pos[c];
          chk(rx_stb_o[c] == es, "R6 rx strobe", rx_stb_o[c], es);
          chk(rx_vld_o[c] == ev, "R7 rx valid", rx_vld_o[c], ev);
          if (ev) chk(rx_byte_o[c*8 +: 8] == rxb[c], "R7 rx byte", rx_byte_o[c*8 +: 8], rxb[c]);
          chk(sync_err_o[c] == ee, "R8 R9 R10 sync_err", sync_err_o[c], ee);
        end
      end
      sep_i = (j < w);
      rx_i  = ((j % 3) == 0);
      for (int c = 0; c < 4; c++) begin
        int k;
        fsx_i[c] = (pos[c] == j);
        k = j - 1 - pos[c] - deff[c];
        if (acc[c] && k >= 0 && k <= 7) rx_i = rxb[c][7 - k];
      end
    end
    fsx_i = '0;
    for (int c = 0; c < 4; c++)
      if (acc[c]) begin
        exp_slot[c] = pos[c] / 8; exp_ok[c] = 1;
      end
    for (int c = 0; c < 4; c++) begin
      chk(slot_o[c*6 +: 6] == 6'(exp_slot[c]), "R2 R8 slot held", slot_o[c*6 +: 6], exp_slot[c]);
      chk(slot_ok_o[c] == exp_ok[c], "R2 slot_ok", slot_ok_o[c], exp_ok[c]);
    end
    chk(rx_delay_o == 6'(dnew), "R5 rx_delay", rx_delay_o, dnew);
    dprev = dnew;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin exp_slot[c] = 0; exp_ok[c] = 0; end
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    // R11: sync before any separation pulse
    fsx_i[2] = 1'b1;
    @(negedge clk);
    fsx_i[2] = 1'b0;
    chk(sync_err_o == 4'b0100, "R11 early sync refused", sync_err_o, 4'b0100);
    chk(slot_ok_o == 0 && tx_oe_o == 0, "R11 no assignment", {slot_ok_o, tx_oe_o}, 0);
    repeat (4) @(negedge clk);
    for (int f = 0; f < 7; f++) run_frame(f);
    // R1: reset mid-operation clears assignment and lag
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_idle("R1 re-reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after re-reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule